// File: doc/BRIEF.md
# Ferroelectric Memory Identity and Capacity Probe

This block runs once after a `start` pulse and discovers what kind of serial ferroelectric memory sits on its SPI link. It first clocks out the identification command and reads back a nine-byte identity response. It then checks the manufacturer byte and the density code in that response. From the density code it derives the capacity in bytes and the number of address bytes that later data commands will need.

If the identity response reports that a serial number is present, the block runs a second, separate transaction that reads eight serial-number bytes. It stores them in reversed byte order.

The results are plain status outputs that hold their value until the next `start`. `done` means the device was accepted and `fail` means it was rejected. `byte_len`, `addr_bytes` and `serial` carry the decoded results. There is no data stream here: results are levels, not a valid/ready interface, so back-pressure does not arise. The SPI shifter is built in and works in mode 0. In that mode the clock idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge, and bits travel most significant first.

Top module: `fram_id_probe`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `byte_len`, `addr_bytes` and `serial` are zero, `spi_cs_n` is high and `spi_sclk` is low.
- R2: A `start` pulse opens one chip-select-low transaction. That transaction sends command 0x9F and then clocks nine response bytes, which is 80 SPI clocks in all, in mode 0 with the MSB first.
- R3: If response byte 6 (counting from 0) is not 0xC2, the block ends with `fail`=1 and runs no second transaction.
- R4: If response byte 7 is below 0x21 or above 0x26, the block ends with `fail`=1 and runs no second transaction.
- R5: For an accepted device, `byte_len` = 1024 × 2^(byte7 − 0x21 + 4). This gives 16384 for 0x21 and 524288 for 0x26.
- R6: `addr_bytes` is 3 when `byte_len` exceeds 65536. Otherwise it is 2.
- R7: For an accepted device with response byte 8 nonzero, a second transaction sends 0xC3 and clocks eight bytes, which is 72 SPI clocks.
- R8: The serial-number byte received in position i (0 first) lands in `serial[8*(7-i)+7 : 8*(7-i)]`.
- R9: For an accepted device with response byte 8 equal to zero, `serial` is all zero and only one transaction occurs.
- R10: Between two transactions, `spi_cs_n` stays high for at least two SPI clock periods. `spi_sclk` never rises while `spi_cs_n` is high.
- R11: `done` and `fail` are never both high. On `fail`, `byte_len`, `addr_bytes` and `serial` are zero.
- R12: `busy` is high from `start` until `done` or `fail`. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a probe |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Device accepted; results valid |
| fail | output | 1 | Device rejected |
| byte_len | output | 20 | Decoded capacity in bytes |
| addr_bytes | output | 2 | Address bytes required (2 or 3; 0 if not accepted) |
| serial | output | 64 | Serial number, byte-reversed |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to device |
| spi_miso | input | 1 | SPI data from device |

## Verification
The following properties are checked on every cycle:
- MOSI stays stable while the SPI clock is high.
- Chip select stays high for the minimum gap between transactions.
- `done` and `fail` are never both set.
- A rejected device leaves zeroed results.
- An accepted capacity is a power of two whose address width matches the 64 KiB boundary.

Other behaviour can only be shown by the bench scenarios, in which a device model answers each command:
- the command bytes actually sent and the number of clocks in each transaction;
- the exact capacity for each density code, including the codes just outside the valid range;
- the byte reversal of the serial number;
- skipping the serial read when it is not advertised;
- ignoring `start` while a probe is running.

// File: rtl/fid_pkg.sv
`timescale 1ns/1ps
package fid_pkg;
  localparam logic [7:0] CMD_IDENT  = 8'h9F;
  localparam logic [7:0] CMD_SERIAL = 8'hC3;
  localparam int         IDENT_LEN  = 9;
  localparam int         SERIAL_LEN = 8;
  localparam int         POS_MAKER  = 6;
  localparam int         POS_DENS   = 7;
  localparam int         POS_SNFLAG = 8;
  localparam logic [7:0] MAKER_OK   = 8'hC2;
  localparam logic [7:0] DENS_LO    = 8'h21;
  localparam logic [7:0] DENS_HI    = 8'h26;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_XFER,
    SQ_GAP
  } seq_state_e;

  typedef enum logic {
    PH_IDENT,
    PH_SERIAL
  } phase_e;
endpackage

// File: rtl/fid_spi_byte.sv
`timescale 1ns/1ps
module fid_spi_byte #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  logic          sclk_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          sh_tx   <= tx_byte;
          bit_cnt <= '0;
          div_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          sh_rx  <= {sh_rx[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = sh_tx[7];
  assign rx_byte   = sh_rx;
  assign byte_done = done_q;

  // R2: mode 0 - data to the device must not move while the clock is high
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(mosi));
endmodule

// File: rtl/fid_size_decode.sv
`timescale 1ns/1ps
module fid_size_decode
  import fid_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic [7:0]       maker,
  input  logic [7:0]       dens,
  output logic             ok,
  output logic [LEN_W-1:0] len,
  output logic [1:0]       addr_bytes
);
  localparam logic [LEN_W-1:0] WIDE_LIMIT = LEN_W'(65536);
  localparam logic [7:0]       BASE_SHIFT = 8'd14;

  logic [7:0] shamt;

  always_comb begin
    ok    = (maker == MAKER_OK) && (dens >= DENS_LO) && (dens <= DENS_HI);
    shamt = (dens - DENS_LO) + BASE_SHIFT;
    len   = ok ? (LEN_W'(1) << shamt) : '0;
    if (!ok)
      addr_bytes = 2'd0;
    else if (len > WIDE_LIMIT)
      addr_bytes = 2'd3;
    else
      addr_bytes = 2'd2;
  end
endmodule

// File: rtl/fid_sequencer.sv
`timescale 1ns/1ps
module fid_sequencer
  import fid_pkg::*;
#(
  parameter int LEN_W   = 20,
  parameter int GAP_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             eng_go,
  output logic [7:0]       eng_tx,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx,
  output logic             cs_n,
  output logic [7:0]       id_maker,
  output logic [7:0]       id_dens,
  input  logic             dec_ok,
  input  logic [LEN_W-1:0] dec_len,
  input  logic [1:0]       dec_addr,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [LEN_W-1:0] byte_len,
  output logic [1:0]       addr_bytes,
  output logic [8*SERIAL_LEN-1:0] serial
);
  localparam int IW = $clog2(IDENT_LEN + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [LEN_W-1:0] WIDE_LIMIT = LEN_W'(65536);

  seq_state_e     state;
  phase_e         phase;
  logic [IW-1:0]  byte_idx;
  logic [GW-1:0]  gap_cnt;
  logic           go_q;
  logic           cs_q;
  logic [7:0]     snflag;
  logic           done_q, fail_q;
  logic [LEN_W-1:0] len_q;
  logic [1:0]     addr_q;
  logic [8*SERIAL_LEN-1:0] ser_q;
  logic [IW-1:0]  last_idx;
  logic [IW-1:0]  rx_pos;

  assign last_idx = (phase == PH_IDENT) ? IW'(IDENT_LEN) : IW'(SERIAL_LEN);
  assign rx_pos   = byte_idx - IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      phase    <= PH_IDENT;
      byte_idx <= '0;
      gap_cnt  <= '0;
      go_q     <= 1'b0;
      cs_q     <= 1'b1;
      id_maker <= '0;
      id_dens  <= '0;
      snflag   <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      len_q    <= '0;
      addr_q   <= '0;
      ser_q    <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            len_q    <= '0;
            addr_q   <= '0;
            ser_q    <= '0;
            phase    <= PH_IDENT;
            byte_idx <= '0;
            cs_q     <= 1'b0;
            go_q     <= 1'b1;
            state    <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (eng_done) begin
            if (byte_idx != '0) begin
              if (phase == PH_IDENT) begin
                if (int'(rx_pos) == POS_MAKER)  id_maker <= eng_rx;
                if (int'(rx_pos) == POS_DENS)   id_dens  <= eng_rx;
                if (int'(rx_pos) == POS_SNFLAG) snflag   <= eng_rx;
              end else begin
                ser_q[(SERIAL_LEN - 1 - int'(rx_pos)) * 8 +: 8] <= eng_rx;
              end
            end
            if (byte_idx == last_idx) begin
              cs_q    <= 1'b1;
              gap_cnt <= '0;
              state   <= SQ_GAP;
            end else begin
              byte_idx <= byte_idx + IW'(1);
              go_q     <= 1'b1;
            end
          end
        end
        SQ_GAP: begin
          gap_cnt <= gap_cnt + GW'(1);
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            state <= SQ_IDLE;
            if (phase == PH_SERIAL) begin
              done_q <= 1'b1;
            end else if (!dec_ok) begin
              fail_q <= 1'b1;
            end else begin
              len_q  <= dec_len;
              addr_q <= dec_addr;
              if (snflag != 8'h00) begin
                phase    <= PH_SERIAL;
                byte_idx <= '0;
                cs_q     <= 1'b0;
                go_q     <= 1'b1;
                state    <= SQ_XFER;
              end else begin
                done_q <= 1'b1;
              end
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign eng_go     = go_q;
  assign eng_tx     = (byte_idx == '0) ?
                      ((phase == PH_IDENT) ? CMD_IDENT : CMD_SERIAL) : 8'h00;
  assign cs_n       = cs_q;
  assign busy       = (state != SQ_IDLE);
  assign done       = done_q;
  assign fail       = fail_q;
  assign byte_len   = len_q;
  assign addr_bytes = addr_q;
  assign serial     = ser_q;

  // R11: the two completion flags exclude each other
  a_r11_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && fail_q));
  // R11: a rejected device leaves no stale results
  a_r11_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (len_q == '0 && addr_q == 2'd0 && ser_q == '0));
  // R5: an accepted capacity is a single power of two
  a_r5_len_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($countones(len_q) == 1));
  // R6: address width follows the 64 KiB boundary
  a_r6_addr_width: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((addr_q == 2'd3) == (len_q > WIDE_LIMIT)));
  // R12: no result flag while a probe runs
  a_r12_busy_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_IDLE) |-> !(done_q || fail_q));
endmodule

// File: rtl/fram_id_probe.sv
`timescale 1ns/1ps
module fram_id_probe
  import fid_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int GAP_SCLK = 2,
  parameter int LEN_W    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [LEN_W-1:0]  byte_len,
  output logic [1:0]        addr_bytes,
  output logic [63:0]       serial,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP_CYC = GAP_SCLK * 2 * CLK_DIV;

  logic             eng_go, eng_done;
  logic [7:0]       eng_tx, eng_rx;
  logic [7:0]       id_maker, id_dens;
  logic             dec_ok;
  logic [LEN_W-1:0] dec_len;
  logic [1:0]       dec_addr;

  fid_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (eng_go),
    .tx_byte  (eng_tx),
    .byte_done(eng_done),
    .rx_byte  (eng_rx),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .miso     (spi_miso)
  );

  fid_size_decode #(.LEN_W(LEN_W)) u_decode (
    .maker     (id_maker),
    .dens      (id_dens),
    .ok        (dec_ok),
    .len       (dec_len),
    .addr_bytes(dec_addr)
  );

  fid_sequencer #(.LEN_W(LEN_W), .GAP_CYC(GAP_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .eng_go    (eng_go),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .cs_n      (spi_cs_n),
    .id_maker  (id_maker),
    .id_dens   (id_dens),
    .dec_ok    (dec_ok),
    .dec_len   (dec_len),
    .dec_addr  (dec_addr),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .byte_len  (byte_len),
    .addr_bytes(addr_bytes),
    .serial    (serial)
  );

  // Chip-select high time watch, used by the gap check below
  logic [15:0] hi_cnt;
  logic        seen_sel;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      seen_sel <= 1'b0;
    end else begin
      if (!spi_cs_n) seen_sel <= 1'b1;
      if (spi_cs_n) begin
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
      end else begin
        hi_cnt <= '0;
      end
    end
  end

  // R10: minimum deselect gap between transactions
  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(spi_cs_n) && seen_sel) |-> (hi_cnt >= 16'(GAP_CYC)));
  // R10: no clock activity while deselected
  a_r10_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/test_fram_id_probe.sv
`timescale 1ns/1ps
module test_fram_id_probe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, fail;
  logic [19:0] byte_len;
  logic [1:0]  addr_bytes;
  logic [63:0] serial;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fram_id_probe i_fram_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .byte_len(byte_len), .addr_bytes(addr_bytes),
    .serial(serial), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] id_rsp [9];
  logic [7:0] sn_rsp [8];
  logic [7:0] cur_cmd;
  int         bit_cnt;
  bit         in_txn = 0;
  int         txn_cnt;
  logic [7:0] cmd_log [4];
  int         bits_log [4];
  int         sclk_viol;
  realtime    t_rise;
  bit         have_rise;
  int         min_gap;

  function automatic logic [7:0] rsp_byte(input logic [7:0] c, input int k);
    if (c == 8'h9F && k < 9) return id_rsp[k];
    if (c == 8'hC3 && k < 8) return sn_rsp[k];
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) begin
    in_txn  = 1;
    bit_cnt = 0;
    cur_cmd = 8'h00;
    if (have_rise) begin
      int g;
      g = int'((($realtime - t_rise) / 8.0));
      if (g < min_gap) min_gap = g;
    end
  end

  always @(posedge spi_cs_n) begin
    if (in_txn) begin
      if (txn_cnt < 4) begin
        cmd_log[txn_cnt]  = cur_cmd;
        bits_log[txn_cnt] = bit_cnt;
      end
      txn_cnt++;
      in_txn    = 0;
      t_rise    = $realtime;
      have_rise = 1;
    end
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n) sclk_viol++;
    else begin
      if (bit_cnt < 8) cur_cmd = {cur_cmd[6:0], spi_mosi};
      bit_cnt++;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && bit_cnt >= 8) begin
      int idx;
      logic [7:0] b;
      idx = bit_cnt - 8;
      b = rsp_byte(cur_cmd, idx / 8);
      #1 spi_miso = b[7 - (idx % 8)];
    end
  end

  // ---------------- vectors ----------------
  typedef struct packed {
    logic [7:0]  maker;
    logic [7:0]  dens;
    logic [7:0]  snflag;
    logic [63:0] sn;
    logic        exp_fail;
    logic [19:0] exp_len;
    logic [1:0]  exp_ab;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'hC2, 8'h21, 8'h00, 64'h1111_2222_3333_4444, 1'b0, 20'd16384,  2'd2}, // R5 R9 low end
    '{8'hC2, 8'h23, 8'h01, 64'h0807_0605_0403_0201, 1'b0, 20'd65536,  2'd2}, // R6 boundary 2
    '{8'hC2, 8'h24, 8'hFF, 64'hA1B2_C3D4_E5F6_0718, 1'b0, 20'd131072, 2'd3}, // R6 3 bytes
    '{8'hC2, 8'h26, 8'h80, 64'hDEAD_BEEF_0123_4567, 1'b0, 20'd524288, 2'd3}, // R5 high end
    '{8'hC1, 8'h22, 8'h01, 64'h5555_5555_5555_5555, 1'b1, 20'd0,      2'd0}, // R3
    '{8'hC2, 8'h20, 8'h01, 64'h6666_6666_6666_6666, 1'b1, 20'd0,      2'd0}, // R4 below
    '{8'hC2, 8'h27, 8'h00, 64'h7777_7777_7777_7777, 1'b1, 20'd0,      2'd0}, // R4 above
    '{8'hC2, 8'h22, 8'h00, 64'h9999_9999_9999_9999, 1'b0, 20'd32768,  2'd2}  // R9
  };

  task automatic load_device(input vec_t v);
    for (int k = 0; k < 9; k++) id_rsp[k] = 8'h30 + 8'(k);
    id_rsp[5] = 8'hC2;  // decoy next to the real maker byte
    id_rsp[6] = v.maker;
    id_rsp[7] = v.dens;
    id_rsp[8] = v.snflag;
    for (int k = 0; k < 8; k++) sn_rsp[k] = v.sn[8*k +: 8];
    txn_cnt   = 0;
    sclk_viol = 0;
    have_rise = 0;
    min_gap   = 1000000;
    for (int k = 0; k < 4; k++) begin cmd_log[k] = 8'h00; bits_log[k] = 0; end
  endtask

  task automatic run_probe(input bit poke_mid);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R12 busy after start", 64'(busy), 64'd1);
    for (int n = 0; n < 5000; n++) begin
      if (poke_mid && n == 200) start = 1'b1;
      if (poke_mid && n == 201) start = 1'b0;
      if (done || fail) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_vector(input vec_t v, input string tag);
    logic [63:0] exp_ser;
    int exp_txn;
    bit two;
    two = !v.exp_fail && (v.snflag != 8'h00);
    exp_txn = two ? 2 : 1;
    exp_ser = '0;
    if (two)
      for (int i = 0; i < 8; i++) exp_ser[8*(7-i) +: 8] = sn_rsp[i];  // R8
    check(fail === v.exp_fail, {tag, " R3/R4 fail flag"}, 64'(fail), 64'(v.exp_fail));
    check(done === !v.exp_fail, {tag, " R11 done flag"}, 64'(done), 64'(!v.exp_fail));
    check(busy === 1'b0, {tag, " R12 busy cleared"}, 64'(busy), 64'd0);
    check(byte_len === v.exp_len, {tag, " R5 byte_len"}, 64'(byte_len), 64'(v.exp_len));
    check(addr_bytes === v.exp_ab, {tag, " R6 addr_bytes"}, 64'(addr_bytes), 64'(v.exp_ab));
    check(serial === exp_ser, {tag, " R8/R9 serial"}, serial, exp_ser);
    check(txn_cnt == exp_txn, {tag, " R7 transaction count"}, 64'(txn_cnt), 64'(exp_txn));
    check(cmd_log[0] == 8'h9F, {tag, " R2 ident command"}, 64'(cmd_log[0]), 64'h9F);
    check(bits_log[0] == 80, {tag, " R2 ident clocks"}, 64'(bits_log[0]), 64'd80);
    if (two) begin
      check(cmd_log[1] == 8'hC3, {tag, " R7 serial command"}, 64'(cmd_log[1]), 64'hC3);
      check(bits_log[1] == 72, {tag, " R7 serial clocks"}, 64'(bits_log[1]), 64'd72);
      check(min_gap >= 8, {tag, " R10 deselect gap"}, 64'(min_gap), 64'd8);
    end
    check(sclk_viol == 0, {tag, " R10 sclk while deselected"}, 64'(sclk_viol), 64'd0);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    load_device(VECS[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R1 flags in reset",
          {61'd0, busy, done, fail}, 64'd0);
    check(byte_len === '0 && addr_bytes === '0 && serial === '0, "R1 results in reset",
          serial, 64'd0);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 bus idle in reset",
          {62'd0, spi_cs_n, spi_sclk}, 64'd2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load_device(VECS[v]);
      run_probe(1'b0);
      check_vector(VECS[v], $sformatf("vec%0d", v));
    end

    // R12: start pulse in the middle of a probe has no effect
    load_device(VECS[2]);
    run_probe(1'b1);
    check_vector(VECS[2], "r12_restart_ignored");

    // R11: a reject after an accept clears the stale results
    load_device(VECS[4]);
    run_probe(1'b0);
    check_vector(VECS[4], "r11_after_accept");

    finish_up();
  end
endmodule